// File: doc/BRIEF.md
# Two-Plane Blink and Configuration Controller

This block keeps the configuration word of a multiplexed display driver and turns it into the few controls that the refresh logic needs. These are which of the two display-data planes (P0 or P1) is scanned out, whether the outputs are blanked, and a one-cycle pulse that tells the character store to clear every digit. Software writes one byte through a simple write strobe and can read the stored settings back at any time.

When blinking is turned on, a timer counts the multiplex oscillator ticks and swaps the active plane at a slow or a fast rate. The rate is a power of two of the tick period. The swapping goes on with no further writes. A blink character is made by loading different data into the two planes. A timer-restart command puts the display back on P0 and starts the count again. This lets the blink phase be lined up with software. The running tick count is brought out so that software can see where the display is in its blink cycle.

Top module: `blink_cfg_ctrl`

## Requirements
- R1: After reset the readback is 0x00, `blank` is 1 (shutdown), `plane_sel` is 0 (P0), `blink_phase` is 0 and `clear_pulse` is 0.
- R2: Bit 0 of the configuration word is the run bit. While it is 0 and `test_mode` is low, `blank` is 1. While it is 1, `blank` is 0.
- R3: While `test_mode` is high, `blank` is 0 whatever the run bit holds.
- R4: A write stores bit 0 (run), bit 2 (fast rate) and bit 3 (blink enable) from the edge at which `wr_en` is sampled. The readback shows those three bits in the same positions, and bits 1, 4, 5, 6 and 7 always read 0.
- R5: While blink enable is 0, `plane_sel` is 0 and `blink_phase` is 0. Disabling takes effect at the edge of the write.
- R6: With blink enabled and bit 2 = 0, `plane_sel` inverts at every 2^K-th sampled tick.
- R7: With blink enabled and bit 2 = 1, `plane_sel` inverts at every 2^(K-1)-th sampled tick.
- R8: A write with bit 4 = 1 sets `plane_sel` to 0 and `blink_phase` to 0 at that edge, even if a tick is sampled at the same edge.
- R9: A write with bit 5 = 1 raises `clear_pulse` for exactly the one cycle after the write edge. Each such write gives its own cycle.
- R10: `blink_phase` counts sampled ticks while blinking, modulo 2^K, so that the plane changes when the low bits of the count wrap.
- R11: Writes are stored while the block is in shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration byte |
| mux_tick | input | 1 | One-cycle multiplex oscillator tick |
| test_mode | input | 1 | Display-test flag; overrides shutdown |
| plane_sel | output | 1 | Active plane: 0 = P0, 1 = P1 |
| blank | output | 1 | Blank the display outputs |
| clear_pulse | output | 1 | One-cycle global digit-clear request |
| cfg_rdata | output | 8 | Configuration readback |
| blink_phase | output | K | Tick count within the blink cycle |

## Verification
The hardest case to reach is a timer-restart or disable write that lands at the same edge as a tick, just as the count is about to wrap. This is where precedence and off-by-one faults show up. Random stimulus sends ticks on about half the cycles and writes on about one cycle in eight, with bits 3 and 4 biased so that blinking stays on long enough to wrap many times. Directed sequences add restart-with-tick, rate changes in the middle of a period, and back-to-back clear writes. A reference model in the bench, built from the requirements, predicts every output in every cycle.

// File: rtl/blink_cfg_pkg.sv
package blink_cfg_pkg;
  localparam int CFG_W     = 8;
  localparam int BIT_RUN   = 0;
  localparam int BIT_FAST  = 2;
  localparam int BIT_BLINK = 3;
  localparam int BIT_TRST  = 4;
  localparam int BIT_CLR   = 5;

  typedef struct packed {
    logic blink_en;
    logic fast;
    logic run;
  } cfg_t;
endpackage

// File: rtl/blink_cfg_reg.sv
module blink_cfg_reg
  import blink_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output cfg_t             cfg_q,
  output cfg_t             cfg_next,
  output logic             restart_req,
  output logic             clear_q
);
  cfg_t cfg_d;
  logic clear_d;

  // next-state
  always_comb begin
    cfg_d   = cfg_q;
    clear_d = 1'b0;
    if (wr_en) begin
      cfg_d.run      = wr_data[BIT_RUN];
      cfg_d.fast     = wr_data[BIT_FAST];
      cfg_d.blink_en = wr_data[BIT_BLINK];
      clear_d        = wr_data[BIT_CLR];
    end
  end

  assign cfg_next    = cfg_d;
  assign restart_req = wr_en & wr_data[BIT_TRST];

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      clear_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      clear_q <= clear_d;
    end
  end
endmodule

// File: rtl/blink_timer.sv
module blink_timer #(
  parameter int K = 4  // K >= 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         enable_next,
  input  logic         fast,
  input  logic         restart,
  output logic [K-1:0] cnt_q,
  output logic         phase_q
);
  localparam int HALF_W = K - 1;
  localparam logic [K-1:0] ONE = {{(K-1){1'b0}}, 1'b1};

  logic [K-1:0] cnt_d;
  logic         phase_d;
  logic         wrap_hit;

  always_comb begin
    wrap_hit = fast ? (&cnt_q[HALF_W-1:0]) : (&cnt_q);
  end

  // next-state
  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (restart || !enable_next) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (tick) begin
      cnt_d = cnt_q + ONE;
      if (wrap_hit) phase_d = ~phase_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/blink_cfg_ctrl.sv
module blink_cfg_ctrl
  import blink_cfg_pkg::*;
#(
  parameter int K = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             mux_tick,
  input  logic             test_mode,
  output logic             plane_sel,
  output logic             blank,
  output logic             clear_pulse,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [K-1:0]     blink_phase
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_int_n;
  cfg_t              cfg_q;
  cfg_t              cfg_next;
  logic              restart_req;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_W-1];

  blink_cfg_reg u_reg (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .cfg_q       (cfg_q),
    .cfg_next    (cfg_next),
    .restart_req (restart_req),
    .clear_q     (clear_pulse)
  );

  blink_timer #(.K(K)) u_tmr (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tick        (mux_tick),
    .enable_next (cfg_next.blink_en),
    .fast        (cfg_q.fast),
    .restart     (restart_req),
    .cnt_q       (blink_phase),
    .phase_q     (plane_sel)
  );

  always_comb begin
    cfg_rdata            = '0;
    cfg_rdata[BIT_RUN]   = cfg_q.run;
    cfg_rdata[BIT_FAST]  = cfg_q.fast;
    cfg_rdata[BIT_BLINK] = cfg_q.blink_en;
  end

  assign blank = ~cfg_q.run & ~test_mode;
endmodule

// File: rtl/blink_cfg_chk.sv
module blink_cfg_chk #(
  parameter int K = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [7:0]   wr_data,
  input logic         mux_tick,
  input logic         test_mode,
  input logic         plane_sel,
  input logic         blank,
  input logic         clear_pulse,
  input logic [7:0]   cfg_rdata,
  input logic [K-1:0] blink_phase
);
  AST_TEST_UNBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> !blank); // R3
  AST_SHUT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[0] && !test_mode) |-> blank); // R2
  AST_OFF_SHOWS_P0: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[3] |-> (!plane_sel && blink_phase == '0)); // R5
  AST_RESTART_P0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4]) |=> (!plane_sel && blink_phase == '0)); // R8
  AST_CLR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |-> $past(wr_en && wr_data[5])); // R9
  AST_PLANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mux_tick && !wr_en) |=> $stable(plane_sel)); // R6
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & 8'hF2) == 8'h00); // R4
endmodule

bind blink_cfg_ctrl blink_cfg_chk #(.K(K)) chk_i (.*);

// File: tb/blink_cfg_ctrl_tb_top.sv
module blink_cfg_ctrl_tb_top;
  localparam int K = 4;
  localparam int MASK = (1 << K) - 1;

  logic clk, rst_n, wr_en, mux_tick, test_mode;
  logic [7:0] wr_data;
  logic plane_sel, blank, clear_pulse;
  logic [7:0] cfg_rdata;
  logic [K-1:0] blink_phase;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  bit m_run, m_fast, m_en, m_phase, m_clr;
  int m_cnt;

  blink_cfg_ctrl #(.K(K)) dut_i (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_fast = 0; m_en = 0; m_phase = 0; m_clr = 0; m_cnt = 0;
    end else begin
      bit new_en, hit;
      m_clr  = wr_en && wr_data[5];
      new_en = wr_en ? wr_data[3] : m_en;
      if ((wr_en && wr_data[4]) || !new_en) begin
        m_cnt = 0; m_phase = 0;
      end else if (mux_tick) begin
        hit = m_fast ? ((m_cnt & (MASK >> 1)) == (MASK >> 1)) : (m_cnt == MASK);
        if (hit) m_phase = ~m_phase;
        m_cnt = (m_cnt + 1) & MASK;
      end
      if (wr_en) begin
        m_run = wr_data[0]; m_fast = wr_data[2]; m_en = wr_data[3];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R3 blank", int'(blank), int'(!m_run && !test_mode));
    chk("R4 R11 readback", int'(cfg_rdata),
        int'(m_run) | (int'(m_fast) << 2) | (int'(m_en) << 3));
    chk("R5 R6 R7 R8 plane", int'(plane_sel), int'(m_phase));
    chk("R10 R8 phase", int'(blink_phase), m_cnt);
    chk("R9 clear", int'(clear_pulse), int'(m_clr));
  endtask

  task automatic step(input bit w, input logic [7:0] d, input bit t, input bit tm);
    @(negedge clk);
    compare_all();
    wr_en = w; wr_data = d; mux_tick = t; test_mode = tm;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_data = '0; mux_tick = 0; test_mode = 0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", int'(cfg_rdata), 0);
    chk("R1 blank", int'(blank), 1);
    chk("R1 plane", int'(plane_sel), 0);
    chk("R1 phase", int'(blink_phase), 0);
    chk("R1 clear", int'(clear_pulse), 0);
    // R11 write in shutdown, unused bits read 0 (R4)
    step(1, 8'hF2, 0, 0);
    step(0, 8'h00, 0, 0);
    // R3 test mode overrides shutdown
    step(0, 8'h00, 0, 1);
    step(0, 8'h00, 0, 0);
    // R6 slow blink with continuous ticks
    step(1, 8'h09, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 8'h00, 1, 0);
    // R7 fast blink mid-period
    step(1, 8'h0D, 1, 0);
    for (int i = 0; i < 30; i++) step(0, 8'h00, 1, 0);
    // R8 restart together with tick near wrap
    for (int i = 0; i < 7; i++) step(0, 8'h00, 1, 0);
    step(1, 8'h1D, 1, 0);
    step(0, 8'h00, 1, 0);
    // R9 back-to-back clear writes
    step(1, 8'h29, 1, 0);
    step(1, 8'h29, 0, 0);
    step(0, 8'h00, 0, 0);
    // R5 disable at tick edge
    step(1, 8'h01, 1, 0);
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 0, 0);
    // random phase
    for (int i = 0; i < 8000; i++) begin
      bit w, t, tm;
      logic [7:0] d;
      w  = ($urandom % 8) == 0;
      t  = $urandom % 2;
      tm = ($urandom % 16) == 0;
      d  = 8'($urandom);
      d[3] = ($urandom % 4) != 0;
      d[4] = ($urandom % 6) == 0;
      step(w, d, t, tm);
    end
    step(0, 8'h00, 0, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule